// File: doc/BRIEF.md
# Gamma Output Refresh Sequencer

This block paces the refresh of fourteen sample-and-hold reference channels. It picks a refresh clock from one of two places. One is an internal clock made by dividing the system clock. The other is an external clock pin, brought in through a two-flop synchronizer. Every falling edge of the chosen clock gives a refresh strobe, and every rising edge gives a hold-switch open strobe. Either strobe can lag its edge by a fixed number of system clocks.

Each refresh strobe copies both stored code banks into holding registers. A synchronized bank-select pin then picks which held bank drives all channel codes. The pin switches the gamma curve within two system clocks. A newly written code reaches its channel only at the next refresh.

The shared clock pin starts tri-stated. It drives the internal clock only after a control write has confirmed internal mode. It goes back to high impedance as soon as external mode is selected.

Top module: `gamma_refresh_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first event, `osc_oe_o`, `refresh_o`, `hold_open_o` and `osc_o` are 0 and every channel code is 0.
- R2: `osc_oe_o` rises one clock after a cycle in which `ctrl_wr_i` is 1 while `osc_ext_sel_i` is 0. It falls one clock after any cycle in which `osc_ext_sel_i` is 1. Otherwise it keeps its value.
- R3: `osc_o` carries the internal clock: low out of reset, and toggling after every DIV_HALF system clocks.
- R4: In internal mode with lag off, a falling edge on `osc_o` gives a one-cycle `refresh_o` pulse one clock later. A rising edge gives `hold_open_o` in the same way.
- R5: In external mode (`osc_ext_sel_i`=1), an edge of `ext_clk_i` gives its strobe in the cycle after the third clock edge that samples the new level. Falling edges give `refresh_o` and rising edges give `hold_open_o`.
- R6: With `lag_en_i`=1, each strobe comes LAG_CYC clocks later than it would with lag off. A new edge of the same kind during a pending lag restarts that lag. A strobe already pending still fires if `lag_en_i` is cleared.
- R7: In the cycle after `refresh_o` is 1, the held codes of both banks take the values on `bank_a_i` and `bank_b_i`. At no other time do the held codes change. Channel c uses bits [c*CODE_W +: CODE_W].
- R8: `ch_code_o` shows held bank B when the synchronized `bank_sel_i` is 1 and held bank A when it is 0. A change of the pin appears after the second clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Pulse: a control write was received |
| osc_ext_sel_i | input | 1 | Clock source: 0 internal, 1 external pin |
| lag_en_i | input | 1 | Enable the fixed strobe lag |
| ext_clk_i | input | 1 | External refresh clock from the pad |
| bank_sel_i | input | 1 | Gamma set select pin, asynchronous |
| bank_a_i | input | NUM_CH*CODE_W | Stored codes, bank A |
| bank_b_i | input | NUM_CH*CODE_W | Stored codes, bank B |
| osc_o | output | 1 | Internal clock toward the pad |
| osc_oe_o | output | 1 | Pad output enable |
| ch_code_o | output | NUM_CH*CODE_W | Held codes of the selected bank |
| refresh_o | output | 1 | Refresh strobe (falling edge of the chosen clock) |
| hold_open_o | output | 1 | Hold-switch open strobe (rising edge of the chosen clock) |

## Verification
The bench first switches clock source while both kinds of edge are still moving through the lag. A design that does not restart the lag would send two strobes where one belongs. A design that drops a pending strobe when lag is cleared would send none.

It writes new bank codes between refreshes. A design that passes the codes straight through would show them early, before the next refresh.

It toggles the select pin with different timing relative to the refresh strobes. A design with the wrong synchronizer depth would switch banks a cycle early or a cycle late.

It also checks that the pad stays tri-stated through reset. An output enable that comes on at power-up, before any control write, is flagged.

// File: rtl/grs_pkg.sv
package grs_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/grs_clk_src.sv
module grs_clk_src
  import grs_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ext_sel_i,
  input  logic      ext_clk_i,
  output logic      int_clk_o,
  output edge_evt_t evt_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          int_q, int_prev_q;
  logic          ext_s1_q, ext_s2_q, ext_prev_q;
  edge_evt_t     int_evt, ext_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      int_q      <= 1'b0;
      int_prev_q <= 1'b0;
      ext_s1_q   <= 1'b0;
      ext_s2_q   <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      if (cnt_q == CW'(DIV_HALF - 1)) begin
        cnt_q <= '0;
        int_q <= ~int_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      int_prev_q <= int_q;
      ext_s1_q   <= ext_clk_i;
      ext_s2_q   <= ext_s1_q;
      ext_prev_q <= ext_s2_q;
    end
  end

  always_comb begin
    int_evt.rise = int_q & ~int_prev_q;
    int_evt.fall = ~int_q & int_prev_q;
    ext_evt.rise = ext_s2_q & ~ext_prev_q;
    ext_evt.fall = ~ext_s2_q & ext_prev_q;
    evt_o        = ext_sel_i ? ext_evt : int_evt;
  end

  assign int_clk_o = int_q;

  // R4
  one_edge_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_o.rise, evt_o.fall}));
endmodule

// File: rtl/grs_lag.sv
module grs_lag #(
  parameter int LAG_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic lag_en_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LAG_CYC + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      // a pending strobe fires even while a new one reloads
      pulse_o <= (evt_i & ~lag_en_i) | (cnt_q == LW'(1));
      if (evt_i && lag_en_i) cnt_q <= LW'(LAG_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  direct_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !lag_en_i) |=> pulse_o);
endmodule

// File: rtl/grs_hold.sv
module grs_hold #(
  parameter int NUM_CH = 14,
  parameter int CODE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic                     sel_i,
  input  logic [NUM_CH*CODE_W-1:0] bank_a_i,
  input  logic [NUM_CH*CODE_W-1:0] bank_b_i,
  output logic [NUM_CH*CODE_W-1:0] code_o
);
  logic [NUM_CH*CODE_W-1:0] held_a_q, held_b_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        held_a_q[c*CODE_W +: CODE_W] <= '0;
        held_b_q[c*CODE_W +: CODE_W] <= '0;
      end else if (cap_i) begin
        held_a_q[c*CODE_W +: CODE_W] <= bank_a_i[c*CODE_W +: CODE_W];
        held_b_q[c*CODE_W +: CODE_W] <= bank_b_i[c*CODE_W +: CODE_W];
      end
    end
    assign code_o[c*CODE_W +: CODE_W] = sel_i ? held_b_q[c*CODE_W +: CODE_W]
                                              : held_a_q[c*CODE_W +: CODE_W];
  end

  // R7
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(held_a_q) && $stable(held_b_q)));
endmodule

// File: rtl/gamma_refresh_seq.sv
module gamma_refresh_seq
  import grs_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int CODE_W   = 8,
  parameter int DIV_HALF = 20,
  parameter int LAG_CYC  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctrl_wr_i,
  input  logic                     osc_ext_sel_i,
  input  logic                     lag_en_i,
  input  logic                     ext_clk_i,
  input  logic                     bank_sel_i,
  input  logic [NUM_CH*CODE_W-1:0] bank_a_i,
  input  logic [NUM_CH*CODE_W-1:0] bank_b_i,
  output logic                     osc_o,
  output logic                     osc_oe_o,
  output logic [NUM_CH*CODE_W-1:0] ch_code_o,
  output logic                     refresh_o,
  output logic                     hold_open_o
);
  localparam int N_KIND = 2; // 0: fall -> refresh, 1: rise -> hold open

  edge_evt_t         evt;
  logic [N_KIND-1:0] evt_v, pulse_v;
  logic              sel_s1_q, sel_s2_q, oe_q;

  grs_clk_src #(.DIV_HALF(DIV_HALF)) i_clk_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_sel_i (osc_ext_sel_i),
    .ext_clk_i (ext_clk_i),
    .int_clk_o (osc_o),
    .evt_o     (evt)
  );

  assign evt_v = {evt.rise, evt.fall};

  for (genvar k = 0; k < N_KIND; k++) begin : g_lag
    grs_lag #(.LAG_CYC(LAG_CYC)) i_lag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_v[k]),
      .lag_en_i (lag_en_i),
      .pulse_o  (pulse_v[k])
    );
  end

  assign refresh_o   = pulse_v[0];
  assign hold_open_o = pulse_v[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_s1_q <= 1'b0;
      sel_s2_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sel_s1_q <= bank_sel_i;
      sel_s2_q <= sel_s1_q;
      if (osc_ext_sel_i)  oe_q <= 1'b0;
      else if (ctrl_wr_i) oe_q <= 1'b1;
    end
  end

  assign osc_oe_o = oe_q;

  grs_hold #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (refresh_o),
    .sel_i    (sel_s2_q),
    .bank_a_i (bank_a_i),
    .bank_b_i (bank_b_i),
    .code_o   (ch_code_o)
  );

  // R2
  pad_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_ext_sel_i |=> !osc_oe_o);
  // R2
  pad_enable_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_oe_o) |-> $past(ctrl_wr_i && !osc_ext_sel_i));
endmodule

// File: tb/test_gamma_refresh_seq.sv
module test_gamma_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 14;
  localparam int CODE_W     = 8;
  localparam int BW         = NUM_CH * CODE_W;
  localparam int HALF       = 20;
  localparam int LAG        = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, ext_sel = 1'b0, lag_en = 1'b0, ext_clk = 1'b0, bank_sel = 1'b0;
  logic [BW-1:0] bank_a = '0, bank_b = '0;
  logic osc, osc_oe, refresh, hold_open;
  logic [BW-1:0] ch_code;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_refresh_seq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .DIV_HALF(HALF), .LAG_CYC(LAG))
  i_gamma_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .osc_ext_sel_i(ext_sel),
    .lag_en_i(lag_en), .ext_clk_i(ext_clk), .bank_sel_i(bank_sel),
    .bank_a_i(bank_a), .bank_b_i(bank_b), .osc_o(osc), .osc_oe_o(osc_oe),
    .ch_code_o(ch_code), .refresh_o(refresh), .hold_open_o(hold_open)
  );

  // behavioural model: edge counts, input histories, due times
  int  j = 0;
  int  pend [2] = '{-1, -1};
  logic ext_q[$];
  logic sel_q[$];
  logic exp_ref = 0, exp_hold = 0, exp_osc = 0, exp_oe = 0;
  logic [BW-1:0] held_a = '0, held_b = '0, exp_code = '0;

  function automatic logic ext_at(int m);
    return (m >= 1) ? ext_q[m-1] : 1'b0;
  endfunction
  function automatic logic sel_at(int m);
    return (m >= 1) ? sel_q[m-1] : 1'b0;
  endfunction

  always @(posedge clk) begin
    logic lj, lp, xr, xf;
    logic [1:0] ev, nxt;
    if (rst_n) begin
      ext_q.push_back(ext_clk);
      sel_q.push_back(bank_sel);
      lj = ((j / HALF) % 2) == 1;
      lp = (j > 0) && ((((j - 1) / HALF) % 2) == 1);
      xr = ext_at(j - 1) && !ext_at(j - 2);
      xf = !ext_at(j - 1) && ext_at(j - 2);
      ev = ext_sel ? {xr, xf} : {lj && !lp, !lj && lp};
      for (int k = 0; k < 2; k++) begin
        nxt[k] = (ev[k] && !lag_en) || (pend[k] == j + 1);
        if (ev[k] && lag_en) pend[k] = j + 1 + LAG;
      end
      if (exp_ref) begin
        held_a = bank_a;
        held_b = bank_b;
      end
      exp_ref  = nxt[0];
      exp_hold = nxt[1];
      if (ext_sel) exp_oe = 0;
      else if (ctrl_wr) exp_oe = 1;
      j++;
      exp_osc  = ((j / HALF) % 2) == 1;
      exp_code = sel_at(j - 1) ? held_b : held_a;
    end
  end

  task automatic chk(logic [BW-1:0] act, logic [BW-1:0] expv, string tag);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(BW'(refresh),   BW'(exp_ref),  "R4 R5 R6 refresh");
      chk(BW'(hold_open), BW'(exp_hold), "R4 R5 R6 hold_open");
      chk(BW'(osc),       BW'(exp_osc),  "R3 osc");
      chk(BW'(osc_oe),    BW'(exp_oe),   "R2 osc_oe");
      chk(ch_code,        exp_code,      "R7 R8 codes");
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic ext, logic lag);
    @(negedge clk);
    ext_sel = ext; lag_en = lag; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic load_banks(int seed);
    for (int c = 0; c < NUM_CH; c++) begin
      bank_a[c*CODE_W +: CODE_W] = CODE_W'(seed + c * 17);
      bank_b[c*CODE_W +: CODE_W] = CODE_W'(255 - seed - c * 9);
    end
  endtask

  task automatic run_ext(int half, int n);
    for (int i = 0; i < n; i++) begin
      if (i % half == 0) ext_clk = ~ext_clk;
      @(negedge clk);
    end
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk(BW'(osc_oe), '0, "R1 oe in reset");
    chk(BW'({refresh, hold_open}), '0, "R1 strobes in reset");
    chk(ch_code, '0, "R1 codes in reset");
    load_banks(3);
    rst_n = 1'b1;
    idle(5);
    chk(BW'(osc_oe), '0, "R1 pad tri-stated after reset");
    idle(60);
    wr_ctrl(1'b0, 1'b0);              // R2 enable pad
    idle(100);
    load_banks(40);                   // R7 visible only at next refresh
    idle(50);
    bank_sel = 1'b1;                  // R8
    idle(37);
    bank_sel = 1'b0; idle(1); bank_sel = 1'b1;
    idle(60);
    wr_ctrl(1'b0, 1'b1);              // R6 lag on
    idle(90);
    load_banks(99);
    idle(70);
    lag_en = 1'b0;                    // R6 pending still fires
    idle(50);
    lag_en = 1'b1;
    idle(20);
    wr_ctrl(1'b1, 1'b1);              // R5 external, R2 release
    run_ext(12, 200);
    lag_en = 1'b0;
    run_ext(9, 180);
    load_banks(200);
    bank_sel = 1'b0;
    run_ext(5, 120);
    lag_en = 1'b1;
    run_ext(16, 200);
    wr_ctrl(1'b0, 1'b1);              // back to internal mid-lag
    idle(30);
    wr_ctrl(1'b0, 1'b0);
    idle(150);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule